// File: doc/BRIEF.md
# PCI Slot Hotplug Event Controller

This block records insertion and removal events for up to 32 PCI slots and drives a level-sensitive system control interrupt so that firmware can service them. Side inputs deliver one event per cycle: a slot number, an insert-or-remove flag and a flag that marks an insertion as present at boot. Each recorded event wipes both slot bitmaps and leaves exactly one bit, in the up bitmap for an insertion or the down bitmap for a removal. It also latches the hotplug bit in the first general-purpose event status byte.

Software reaches the block over a simple I/O read/write bus. It reads the up and down bitmaps and the removable-slot mask. It clears event status by writing ones and sets the enables. It asks for a slot to be removed by writing the eject register, and the block answers with a one-cycle eject strobe that names the slot. A static input marks slots that may never be hot-removed. A fixed power-management pending-event input is merged into the interrupt.

Top module: `slot_hotplug_ctrl`

## Requirements
- R1: Address map: up bitmap at 0xAE00, down bitmap at 0xAE04, eject at 0xAE08, removable mask at 0xAE0C (32-bit). The event block starts at 0xAFE0, with status bytes at offsets 0-1 and enable bytes at offsets 2-3, each read in data bits 7:0. Read data is zero when io_rd_i is low or the address is unmapped.
- R2: An insertion event that is not coldplug sets the up bitmap to exactly 1<<slot, clears the down bitmap and sets bit 1 of status byte 0 on the next clock edge.
- R3: A removal event sets the down bitmap to exactly 1<<slot, clears the up bitmap and sets bit 1 of status byte 0. The coldplug flag has no effect on removals.
- R4: An insertion with the coldplug flag set changes neither bitmap nor any status bit.
- R5: Writing a status byte clears each bit written as 1 and keeps each bit written as 0. Enable bytes read back what was written. Writes to the up and down bitmap addresses are ignored.
- R6: When an accepted event and a write of 1 to status byte 0 bit 1 fall in the same cycle, the bit ends up set.
- R7: sci_o is high exactly while (status byte 0 AND enable byte 0) has bit 1 set, or pm_evt_i is high.
- R8: A write to the eject register with a nonzero value selects the index of the lowest set bit. In the next cycle eject_valid_o pulses high for one cycle with eject_slot_o set to that index, but only if that slot is not marked in nohp_mask_i. A zero value produces no pulse. The eject register reads as zero.
- R9: The removable mask reads as the bitwise inverse of nohp_mask_i, and writes to it are ignored.
- R10: After reset, the bitmaps, status bytes and enable bytes are zero and eject_valid_o is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| io_addr_i | input | 16 | I/O address |
| io_wr_i | input | 1 | Write strobe, one cycle per write |
| io_rd_i | input | 1 | Read enable; read data is combinational |
| io_wdata_i | input | 32 | Write data |
| io_rdata_o | output | 32 | Read data |
| ev_valid_i | input | 1 | Hotplug event present this cycle |
| ev_slot_i | input | 5 | Slot number of the event |
| ev_insert_i | input | 1 | 1 insertion, 0 removal |
| ev_cold_i | input | 1 | Insertion of a device present at boot |
| pm_evt_i | input | 1 | Fixed power-management pending event |
| nohp_mask_i | input | 32 | Slots that are not hotpluggable (static) |
| sci_o | output | 1 | Level system control interrupt |
| eject_valid_o | output | 1 | Eject strobe |
| eject_slot_o | output | 5 | Slot to remove while the strobe is high |

## Verification
The assertions take nohp_mask_i as a static strap, so a strobed slot can be compared with the mask in the cycle the strobe appears. They also take at most one event per cycle from a single source. The bench holds the mask constant for the whole run and drives events only through the single event port. Random I/O writes and events are mixed freely, including events in the same cycle as status clears.

// File: rtl/hp_pkg.sv
package hp_pkg;
  localparam int unsigned ADDR_W = 16;
  localparam int unsigned DATA_W = 32;
  localparam int unsigned HP_BIT = 1;  // hotplug bit in status byte 0

  typedef struct packed {
    logic valid;
    logic insert;
    logic cold;
  } hp_ev_t;
endpackage

// File: rtl/hp_gpe_regs.sv
module hp_gpe_regs #(
  parameter int unsigned NBYTES = 2,
  localparam int unsigned OFF_W = $clog2(2 * NBYTES)
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   wr_i,
  input  logic [OFF_W-1:0]       off_i,
  input  logic [7:0]             wdata_i,
  input  logic                   hp_set_i,
  output logic [NBYTES-1:0][7:0] sts_o,
  output logic [NBYTES-1:0][7:0] en_o,
  output logic [7:0]             rdata_o
);
  logic [NBYTES-1:0][7:0] sts_q, en_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sts_q <= '0;
      en_q  <= '0;
    end else begin
      for (int k = 0; k < int'(NBYTES); k++) begin
        if (wr_i && off_i == OFF_W'(k)) sts_q[k] <= sts_q[k] & ~wdata_i;
        if (wr_i && off_i == OFF_W'(NBYTES + k)) en_q[k] <= wdata_i;
      end
      // event has priority over a same-cycle clear
      if (hp_set_i) sts_q[0][hp_pkg::HP_BIT] <= 1'b1;
    end
  end

  always_comb begin
    rdata_o = '0;
    for (int k = 0; k < int'(NBYTES); k++) begin
      if (off_i == OFF_W'(k)) rdata_o = sts_q[k];
      if (off_i == OFF_W'(NBYTES + k)) rdata_o = en_q[k];
    end
  end

  assign sts_o = sts_q;
  assign en_o  = en_q;
endmodule

// File: rtl/hp_slot_track.sv
module hp_slot_track #(
  parameter int unsigned NSLOTS = 32,
  localparam int unsigned SLOT_W = $clog2(NSLOTS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  hp_pkg::hp_ev_t    ev_i,
  input  logic [SLOT_W-1:0] slot_i,
  output logic [NSLOTS-1:0] up_o,
  output logic [NSLOTS-1:0] down_o,
  output logic              hp_set_o
);
  logic [NSLOTS-1:0] up_q, down_q, slot_bit;
  logic take;

  assign take     = ev_i.valid && !(ev_i.insert && ev_i.cold);
  assign slot_bit = NSLOTS'(1) << slot_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      up_q   <= '0;
      down_q <= '0;
    end else if (take) begin
      up_q   <= ev_i.insert ? slot_bit : '0;
      down_q <= ev_i.insert ? '0 : slot_bit;
    end
  end

  assign up_o     = up_q;
  assign down_o   = down_q;
  assign hp_set_o = take;
endmodule

// File: rtl/hp_eject_dec.sv
module hp_eject_dec #(
  parameter int unsigned NSLOTS = 32,
  localparam int unsigned SLOT_W = $clog2(NSLOTS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [NSLOTS-1:0] wdata_i,
  input  logic [NSLOTS-1:0] nohp_i,
  output logic              valid_o,
  output logic [SLOT_W-1:0] slot_o
);
  logic              found;
  logic [SLOT_W-1:0] idx;
  logic              valid_q;
  logic [SLOT_W-1:0] slot_q;

  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = int'(NSLOTS) - 1; i >= 0; i--) begin
      if (wdata_i[i]) begin
        found = 1'b1;
        idx   = SLOT_W'(i);
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      slot_q  <= '0;
    end else begin
      valid_q <= wr_i && found && !nohp_i[idx];
      if (wr_i && found) slot_q <= idx;
    end
  end

  assign valid_o = valid_q;
  assign slot_o  = slot_q;
endmodule

// File: rtl/slot_hotplug_ctrl.sv
module slot_hotplug_ctrl #(
  parameter int unsigned NSLOTS    = 32,
  parameter int unsigned GPE_BYTES = 2,
  parameter logic [15:0] HP_BASE   = 16'hAE00,
  parameter logic [15:0] GPE_BASE  = 16'hAFE0,
  localparam int unsigned SLOT_W   = $clog2(NSLOTS),
  localparam int unsigned GPE_AW   = $clog2(2 * GPE_BYTES)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [15:0]       io_addr_i,
  input  logic              io_wr_i,
  input  logic              io_rd_i,
  input  logic [31:0]       io_wdata_i,
  output logic [31:0]       io_rdata_o,
  input  logic              ev_valid_i,
  input  logic [SLOT_W-1:0] ev_slot_i,
  input  logic              ev_insert_i,
  input  logic              ev_cold_i,
  input  logic              pm_evt_i,
  input  logic [NSLOTS-1:0] nohp_mask_i,
  output logic              sci_o,
  output logic              eject_valid_o,
  output logic [SLOT_W-1:0] eject_slot_o
);
  localparam logic [15:0] DOWN_ADDR = HP_BASE + 16'd4;
  localparam logic [15:0] EJ_ADDR   = HP_BASE + 16'd8;
  localparam logic [15:0] RMV_ADDR  = HP_BASE + 16'd12;

  hp_pkg::hp_ev_t ev;
  logic [NSLOTS-1:0] up_w, down_w;
  logic [GPE_BYTES-1:0][7:0] sts_w, en_w;
  logic [7:0] gpe_rdata;
  logic hp_set, gpe_hit, ej_wr;

  assign ev      = '{valid: ev_valid_i, insert: ev_insert_i, cold: ev_cold_i};
  assign gpe_hit = io_addr_i[15:GPE_AW] == GPE_BASE[15:GPE_AW];
  assign ej_wr   = io_wr_i && io_addr_i == EJ_ADDR;

  hp_slot_track #(.NSLOTS(NSLOTS)) u_track (
    .clk_i, .rst_ni, .ev_i(ev), .slot_i(ev_slot_i),
    .up_o(up_w), .down_o(down_w), .hp_set_o(hp_set)
  );

  hp_gpe_regs #(.NBYTES(GPE_BYTES)) u_gpe (
    .clk_i, .rst_ni, .wr_i(io_wr_i && gpe_hit), .off_i(io_addr_i[GPE_AW-1:0]),
    .wdata_i(io_wdata_i[7:0]), .hp_set_i(hp_set),
    .sts_o(sts_w), .en_o(en_w), .rdata_o(gpe_rdata)
  );

  hp_eject_dec #(.NSLOTS(NSLOTS)) u_eject (
    .clk_i, .rst_ni, .wr_i(ej_wr), .wdata_i(io_wdata_i[NSLOTS-1:0]),
    .nohp_i(nohp_mask_i), .valid_o(eject_valid_o), .slot_o(eject_slot_o)
  );

  assign sci_o = pm_evt_i || (sts_w[0][hp_pkg::HP_BIT] && en_w[0][hp_pkg::HP_BIT]);

  always_comb begin
    io_rdata_o = '0;
    if (io_rd_i) begin
      if (gpe_hit)                     io_rdata_o = 32'(gpe_rdata);
      else if (io_addr_i == HP_BASE)   io_rdata_o = 32'(up_w);
      else if (io_addr_i == DOWN_ADDR) io_rdata_o = 32'(down_w);
      else if (io_addr_i == RMV_ADDR)  io_rdata_o = 32'(~nohp_mask_i);
    end
  end
endmodule

// File: rtl/slot_hotplug_ctrl_chk.sv
module slot_hotplug_ctrl_chk #(
  parameter int unsigned NSLOTS = 32,
  localparam int unsigned SLOT_W = $clog2(NSLOTS)
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              ev_valid_i,
  input logic [SLOT_W-1:0] ev_slot_i,
  input logic              ev_insert_i,
  input logic              ev_cold_i,
  input logic              pm_evt_i,
  input logic [NSLOTS-1:0] nohp_mask_i,
  input logic [NSLOTS-1:0] up_i,
  input logic [NSLOTS-1:0] down_i,
  input logic [7:0]        sts0_i,
  input logic [7:0]        en0_i,
  input logic              sci_o,
  input logic              eject_valid_o,
  input logic [SLOT_W-1:0] eject_slot_o
);
  // R2
  insert_marks_up_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ev_valid_i && ev_insert_i && !ev_cold_i) |=> (up_i[$past(ev_slot_i)] && down_i == '0));

  // R3
  remove_marks_down_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ev_valid_i && !ev_insert_i) |=> (down_i[$past(ev_slot_i)] && up_i == '0));

  // R6
  event_sets_status_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ev_valid_i && !(ev_insert_i && ev_cold_i)) |=> sts0_i[1]);

  // R4
  cold_silent_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ev_valid_i && ev_insert_i && ev_cold_i) |=> ($stable(up_i) && $stable(down_i)));

  // R2
  single_bit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones({up_i, down_i}) <= 1);

  // R7
  sci_level_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sci_o == (pm_evt_i || (sts0_i[1] && en0_i[1])));

  // R8
  eject_allowed_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eject_valid_o |-> !nohp_mask_i[eject_slot_o]);
endmodule

bind slot_hotplug_ctrl slot_hotplug_ctrl_chk #(.NSLOTS(NSLOTS)) u_chk (
  .clk_i, .rst_ni, .ev_valid_i, .ev_slot_i, .ev_insert_i, .ev_cold_i,
  .pm_evt_i, .nohp_mask_i, .up_i(up_w), .down_i(down_w),
  .sts0_i(sts_w[0]), .en0_i(en_w[0]), .sci_o, .eject_valid_o, .eject_slot_o
);

// File: tb/slot_hotplug_ctrl_test.sv
`timescale 1ns/1ps
module slot_hotplug_ctrl_test;
  localparam logic [15:0] A_UP = 16'hAE00, A_DN = 16'hAE04, A_EJ = 16'hAE08,
                          A_RMV = 16'hAE0C, A_GPE = 16'hAFE0;
  localparam logic [31:0] NOHP = 32'h0000_0007;

  logic clk_i = 0, rst_ni = 0;
  logic [15:0] io_addr_i = '0;
  logic io_wr_i = 0, io_rd_i = 0;
  logic [31:0] io_wdata_i = '0, io_rdata_o;
  logic ev_valid_i = 0, ev_insert_i = 0, ev_cold_i = 0, pm_evt_i = 0;
  logic [4:0] ev_slot_i = '0, eject_slot_o;
  logic [31:0] nohp_mask_i = NOHP;
  logic sci_o, eject_valid_o;

  int checks = 0, errors = 0;
  bit done = 0;
  logic [31:0] m_up = 0, m_dn = 0;
  logic [7:0] m_sts [2] = '{8'h0, 8'h0};
  logic [7:0] m_en [2] = '{8'h0, 8'h0};
  logic m_ej_v = 0;
  logic [4:0] m_ej_s = 0;

  always #4 clk_i = ~clk_i;

  slot_hotplug_ctrl uut (.*);

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic rd(logic [15:0] a, output logic [31:0] d);
    io_addr_i = a; io_rd_i = 1; #1; d = io_rdata_o; io_rd_i = 0;
  endtask

  function automatic logic [5:0] lowest(logic [31:0] v);
    for (int i = 0; i < 32; i++) if (v[i]) return {1'b1, 5'(i)};
    return 6'd0;
  endfunction

  // drive one cycle of stimulus and update the model
  task automatic step(bit ev, bit ins, bit cold, logic [4:0] slot,
                      bit wr, logic [15:0] a, logic [31:0] d);
    logic [5:0] lw;
    ev_valid_i = ev; ev_insert_i = ins; ev_cold_i = cold; ev_slot_i = slot;
    io_wr_i = wr; io_addr_i = a; io_wdata_i = d;
    m_ej_v = 0;
    if (wr) begin
      if (a == A_GPE)          m_sts[0] &= ~d[7:0];
      if (a == A_GPE + 16'd1)  m_sts[1] &= ~d[7:0];
      if (a == A_GPE + 16'd2)  m_en[0] = d[7:0];
      if (a == A_GPE + 16'd3)  m_en[1] = d[7:0];
      if (a == A_EJ) begin
        lw = lowest(d);
        m_ej_v = lw[5] && !NOHP[lw[4:0]];
        m_ej_s = lw[4:0];
      end
    end
    if (ev && !(ins && cold)) begin
      m_up = ins ? (32'd1 << slot) : 0;
      m_dn = ins ? 0 : (32'd1 << slot);
      m_sts[0][1] = 1'b1;
    end
    @(negedge clk_i);
    ev_valid_i = 0; io_wr_i = 0;
  endtask

  task automatic verify(string tag);
    logic [31:0] d;
    check({tag, " R8 eject strobe"}, 32'(eject_valid_o), 32'(m_ej_v));
    if (m_ej_v) check({tag, " R8 eject slot"}, 32'(eject_slot_o), 32'(m_ej_s));
    check({tag, " R7 sci"}, 32'(sci_o), 32'(pm_evt_i | (m_sts[0][1] & m_en[0][1])));
    rd(A_UP, d);  check({tag, " R2 up"}, d, m_up);
    rd(A_DN, d);  check({tag, " R3 down"}, d, m_dn);
    rd(A_GPE, d); check({tag, " R5 sts0"}, d, 32'(m_sts[0]));
    rd(A_GPE + 16'd1, d); check({tag, " R5 sts1"}, d, 32'(m_sts[1]));
    rd(A_GPE + 16'd2, d); check({tag, " R5 en0"}, d, 32'(m_en[0]));
    rd(A_GPE + 16'd3, d); check({tag, " R5 en1"}, d, 32'(m_en[1]));
    rd(A_RMV, d); check({tag, " R9 rmv"}, d, ~NOHP);
    rd(A_EJ, d);  check({tag, " R8 eject reads 0"}, d, 32'h0);
    @(negedge clk_i);
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    void'($urandom(32'd2024));
    #20; @(negedge clk_i); rst_ni = 1; @(negedge clk_i);
    // R10 reset state
    verify("R10 reset");
    io_addr_i = A_UP; #1;
    check("R1 no read strobe gives zero", io_rdata_o, 32'h0);
    rd(16'h1234, d); check("R1 unmapped", d, 32'h0);

    // directed corners
    step(1, 1, 1, 5'd9, 0, 0, 0);  verify("R4 cold insert");
    step(1, 1, 0, 5'd9, 0, 0, 0);  verify("R2 insert 9");
    step(1, 0, 1, 5'd31, 0, 0, 0); verify("R3 cold-flag remove 31");
    step(0, 0, 0, 0, 1, A_UP, 32'hFFFF_FFFF);  verify("R5 up write ignored");
    step(0, 0, 0, 0, 1, A_DN, 32'h0);          verify("R5 down write ignored");
    step(0, 0, 0, 0, 1, A_RMV, 32'h0);         verify("R9 rmv write ignored");
    step(0, 0, 0, 0, 1, A_GPE + 16'd2, 32'h02); verify("R7 enable hp");
    step(1, 1, 0, 5'd4, 1, A_GPE, 32'hFF);      verify("R6 event beats clear");
    step(0, 0, 0, 0, 1, A_GPE, 32'h02);         verify("R5 clear bit1");
    pm_evt_i = 1; #1; verify("R7 pm event"); pm_evt_i = 0;
    step(0, 0, 0, 0, 1, A_EJ, 32'h0);           verify("R8 zero eject");
    step(0, 0, 0, 0, 1, A_EJ, 32'hF000_0010);   verify("R8 lowest bit 4");
    step(0, 0, 0, 0, 1, A_EJ, 32'h0000_0006);   verify("R8 blocked slot 1");

    // random mix
    for (int n = 0; n < 400; n++) begin
      int op = $urandom_range(0, 5);
      logic [31:0] v = $urandom();
      logic [15:0] a;
      if ($urandom_range(0, 3) == 0) v = 32'd1 << v[4:0];
      case (op)
        0: a = A_GPE + 16'($urandom_range(0, 3));
        1: a = A_EJ;
        2: a = A_UP + 16'(4 * $urandom_range(0, 3));
        default: a = A_GPE + 16'($urandom_range(0, 3));
      endcase
      pm_evt_i = ($urandom_range(0, 7) == 0);
      step($urandom_range(0, 1), $urandom_range(0, 1), ($urandom_range(0, 3) == 0),
           5'($urandom()), (op != 5), a, v);
      verify("R2 R3 R5 R8 random");
    end
    pm_evt_i = 0;
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule